// File: doc/BRIEF.md
# Segment Access Permission Checker

This block decides whether one memory reference through a segment descriptor may go ahead. Each cycle that `req_valid` is high, it takes an already decoded descriptor (base, 20-bit limit, attribute byte and a three-bit flag group), the current privilege level, the kind of reference (read, write or execute/far transfer), the offset and the reference size in bytes. One clock later it reports pass or a single fault class, the linear address, and the attribute byte to write back. On a pass, the write-back byte has its touched bit set.

The check covers the following:
- scaling of the limit by granularity;
- limits for segments that grow up and for data segments that grow down, applied to every byte of a multi-byte reference;
- read, write and execute rules for code and data segments;
- the one-sided privilege rule for conforming code;
- a wide-address mode that skips the base and the limit.

Call gates and task switches are handled elsewhere.

Top module: `seg_access_check`

## Requirements
- R1: Outputs are registered. A request presented in one cycle is answered on the next rising edge, with `rsp_valid` equal to the `req_valid` of that cycle. An active-low synchronous reset drives every output to zero.
- R2: Fault codes are none=0, absent=1, system=2, descriptor=3, type=4, privilege=5, limit=6. When several faults apply, the lowest nonzero code is reported. `rsp_ok` is 1 exactly when the code is 0. Attribute bit 7 clear gives code 1.
- R3: Attribute bit 4 clear (system segment) gives code 2.
- R4: Flag bit 0 (wide code) and flag bit 1 (32-bit default) both set give code 3.
- R5: Attribute bit 3 set marks code and clear marks data. Kind encoding is read=0, write=1, execute=2, and 3 is reserved. Code 4 is given for each of these: execute of data, write of code, read of code with attribute bit 1 clear, write of data with attribute bit 1 clear, and the reserved kind. Reads of data and execution of code need no permission bit.
- R6: The privilege level DPL is attribute bits 6:5. Code 5 is given in three cases: data with CPL > DPL; code with attribute bit 2 clear and CPL != DPL; code with attribute bit 2 set and CPL < DPL.
- R7: Flag bit 2 set makes the effective limit limit*4096+4095. When it is clear, the effective limit equals the limit.
- R8: Segments that grow up require the last byte, offset+size-1, to be no greater than the effective limit, using 33-bit arithmetic, so that a wrap past 2^32 also faults. A size of 0 counts as 1 byte. A breach gives code 6.
- R9: Data with attribute bit 2 set grows down and requires offset > effective limit, with no wrap of the last byte. A breach gives code 6.
- R10: With `long_mode` high, no limit fault is raised and the linear address equals the offset.
- R11: With `long_mode` low, the linear address is base+offset modulo 2^32.
- R12: On a pass, `rsp_access` is the input attribute byte with bit 0 set. On any fault it is the input byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 20 | Raw segment limit |
| desc_access | input | 8 | Attribute byte |
| desc_flags | input | 3 | [2] granularity, [1] 32-bit default, [0] wide code |
| cpl | input | 2 | Current privilege level |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| long_mode | input | 1 | Wide-address mode: base and limit skipped |
| offset | input | 32 | Offset within segment |
| acc_size | input | 4 | Bytes touched (0 treated as 1) |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Reference allowed |
| rsp_fault | output | 3 | Fault class |
| rsp_lin_addr | output | 32 | Linear address |
| rsp_access | output | 8 | Attribute byte to write back |

## Verification
The response register is the only state, so any corruption in it appears at the ports one cycle after the request that caused it, and the next request overwrites it. A wrong priority or a wrong limit comparison shows up as a wrong fault code in that same response cycle. A wrong touched-bit update shows up as a changed `rsp_access` on a fault, or as bit 0 still clear on a pass. The bench therefore compares every output in every response cycle against a behavioural model. It covers directed boundary cases for the limit, the privilege rules and wrap-around, and then a long run of random descriptors and offsets.

// File: rtl/seg_chk_pkg.sv
// Shared types and field positions for the segment access checker.
// Assumes the descriptor has already been unpacked into separate fields.
package seg_chk_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_SYSTEM = 3'd2,
        FLT_DESC   = 3'd3,
        FLT_TYPE   = 3'd4,
        FLT_PRIV   = 3'd5,
        FLT_LIMIT  = 3'd6
    } fault_e;

    // attribute byte bit positions
    localparam int AB_PRESENT = 7;
    localparam int AB_DPL_HI  = 6;
    localparam int AB_DPL_LO  = 5;
    localparam int AB_NONSYS  = 4;
    localparam int AB_CODE    = 3;
    localparam int AB_DIRCONF = 2;
    localparam int AB_RWPERM  = 1;
    localparam int AB_TOUCHED = 0;

    // flag group bit positions
    localparam int FL_GRAN  = 2;
    localparam int FL_SZ32  = 1;
    localparam int FL_WIDE  = 0;

endpackage

// File: rtl/seg_limit_unit.sv
// Limit comparison for one reference.
// Scales the raw limit by granularity and checks the whole byte span
// [offset, offset+size-1] against it, for segments that grow up or down.
// A carry out of the address width counts as a breach.
// Assumes LIMIT_W + PAGE_SHIFT <= ADDR_W.
module seg_limit_unit #(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int SIZE_W     = 4
) (
    input  logic [LIMIT_W-1:0] limit_raw,
    input  logic               gran_page,
    input  logic               grows_down,
    input  logic [ADDR_W-1:0]  offset,
    input  logic [SIZE_W-1:0]  size,
    output logic               limit_bad
);
    localparam int SCALED_W = LIMIT_W + PAGE_SHIFT;

    logic [SCALED_W-1:0] scaled;
    logic [ADDR_W-1:0]   eff_limit;
    logic [SIZE_W-1:0]   size_m1;
    logic [ADDR_W:0]     last_byte;
    logic                up_bad;
    logic                down_bad;

    // effective limit from granularity
    always_comb begin
        scaled    = {limit_raw, {PAGE_SHIFT{1'b1}}};
        eff_limit = gran_page ? ADDR_W'(scaled) : ADDR_W'(limit_raw);
    end

    // address of the final byte touched, one extra bit to catch wrap
    always_comb begin
        size_m1   = (size == '0) ? '0 : size - SIZE_W'(1);
        last_byte = {1'b0, offset} + (ADDR_W+1)'(size_m1);
    end

    // breach tests for both directions
    always_comb begin
        up_bad    = last_byte[ADDR_W] | (last_byte[ADDR_W-1:0] > eff_limit);
        down_bad  = last_byte[ADDR_W] | (offset <= eff_limit);
        limit_bad = grows_down ? down_bad : up_bad;
    end

endmodule

// File: rtl/seg_perm_unit.sv
// Type, presence and privilege screening for one reference.
// Produces the highest-priority fault of the non-limit classes, or none.
// Assumes cpl and the privilege field use 0 as most privileged.
module seg_perm_unit
    import seg_chk_pkg::*;
(
    input  logic [7:0] attr,
    input  logic [2:0] flags,
    input  logic [1:0] cpl,
    input  logic [1:0] kind,
    output fault_e     perm_fault
);
    logic       is_code;
    logic       rw_perm;
    logic       dirconf;
    logic [1:0] dpl;
    logic       type_bad;
    logic       priv_bad;
    logic       desc_bad;

    // field extraction
    always_comb begin
        is_code  = attr[AB_CODE];
        rw_perm  = attr[AB_RWPERM];
        dirconf  = attr[AB_DIRCONF];
        dpl      = attr[AB_DPL_HI:AB_DPL_LO];
        desc_bad = flags[FL_WIDE] & flags[FL_SZ32];
    end

    // kind versus segment type
    always_comb begin
        unique case (acc_kind_e'(kind))
            KIND_READ:  type_bad = is_code & ~rw_perm;
            KIND_WRITE: type_bad = is_code | ~rw_perm;
            KIND_EXEC:  type_bad = ~is_code;
            default:    type_bad = 1'b1;
        endcase
    end

    // privilege rule, one-sided for conforming code
    always_comb begin
        if (!is_code)     priv_bad = (cpl > dpl);
        else if (dirconf) priv_bad = (cpl < dpl);
        else              priv_bad = (cpl != dpl);
    end

    // priority encode
    always_comb begin
        if (!attr[AB_PRESENT])     perm_fault = FLT_ABSENT;
        else if (!attr[AB_NONSYS]) perm_fault = FLT_SYSTEM;
        else if (desc_bad)         perm_fault = FLT_DESC;
        else if (type_bad)         perm_fault = FLT_TYPE;
        else if (priv_bad)         perm_fault = FLT_PRIV;
        else                       perm_fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_access_check.sv
// Registered segment access checker.
// Combines screening and limit results, forms the linear address and the
// write-back attribute byte, and registers all of it one cycle after the
// request. Limit faults are suppressed in wide-address mode.
module seg_access_check
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int SIZE_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  desc_base,
    input  logic [LIMIT_W-1:0] desc_limit,
    input  logic [7:0]         desc_access,
    input  logic [2:0]         desc_flags,
    input  logic [1:0]         cpl,
    input  logic [1:0]         acc_kind,
    input  logic               long_mode,
    input  logic [ADDR_W-1:0]  offset,
    input  logic [SIZE_W-1:0]  acc_size,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [2:0]         rsp_fault,
    output logic [ADDR_W-1:0]  rsp_lin_addr,
    output logic [7:0]         rsp_access
);
    fault_e            perm_fault;
    fault_e            fault_nxt;
    logic              limit_bad;
    logic              grows_down;
    logic [ADDR_W-1:0] lin_nxt;
    logic [7:0]        attr_nxt;

    seg_perm_unit u_perm (
        .attr       (desc_access),
        .flags      (desc_flags),
        .cpl        (cpl),
        .kind       (acc_kind),
        .perm_fault (perm_fault)
    );

    seg_limit_unit #(
        .ADDR_W     (ADDR_W),
        .LIMIT_W    (LIMIT_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .SIZE_W     (SIZE_W)
    ) u_limit (
        .limit_raw  (desc_limit),
        .gran_page  (desc_flags[FL_GRAN]),
        .grows_down (grows_down),
        .offset     (offset),
        .size       (acc_size),
        .limit_bad  (limit_bad)
    );

    // only data segments can grow down
    always_comb grows_down = ~desc_access[AB_CODE] & desc_access[AB_DIRCONF];

    // final fault, address and write-back byte
    always_comb begin
        if (perm_fault != FLT_NONE)      fault_nxt = perm_fault;
        else if (!long_mode && limit_bad) fault_nxt = FLT_LIMIT;
        else                              fault_nxt = FLT_NONE;
        lin_nxt  = long_mode ? offset : desc_base + offset;
        attr_nxt = desc_access;
        if (fault_nxt == FLT_NONE) attr_nxt[AB_TOUCHED] = 1'b1;
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_ok       <= 1'b0;
            rsp_fault    <= '0;
            rsp_lin_addr <= '0;
            rsp_access   <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_ok       <= (fault_nxt == FLT_NONE);
            rsp_fault    <= fault_nxt;
            rsp_lin_addr <= lin_nxt;
            rsp_access   <= attr_nxt;
        end
    end

endmodule

// File: rtl/seg_access_check_sva.sv
// Port-level properties for seg_access_check, attached by bind.
module seg_access_check_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [7:0]        desc_access,
    input logic [2:0]        desc_flags,
    input logic              long_mode,
    input logic [ADDR_W-1:0] offset,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic [2:0]        rsp_fault,
    input logic [ADDR_W-1:0] rsp_lin_addr,
    input logic [7:0]        rsp_access
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_ok_matches_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok == (rsp_fault == 3'd0)));

    p_absent_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !desc_access[7]) |=> (rsp_fault == 3'd1));

    p_desc_combo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && desc_access[7] && desc_access[4] && desc_flags[1] && desc_flags[0])
        |=> (rsp_fault == 3'd3));

    p_wide_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && long_mode) |=> (rsp_lin_addr == $past(offset) && rsp_fault != 3'd6));

    p_touch_on_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> rsp_access[0]);

    p_keep_on_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_ok || rsp_access == $past(desc_access)));

endmodule

bind seg_access_check seg_access_check_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/seg_access_check_bench.sv
// Self-checking bench: behavioural reference model compared every response cycle.
module seg_access_check_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] desc_base;
    logic [19:0] desc_limit;
    logic [7:0]  desc_access;
    logic [2:0]  desc_flags;
    logic [1:0]  cpl;
    logic [1:0]  acc_kind;
    logic        long_mode;
    logic [31:0] offset;
    logic [3:0]  acc_size;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_lin_addr;
    logic [7:0]  rsp_access;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    seg_access_check u_seg_access_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .desc_base(desc_base), .desc_limit(desc_limit), .desc_access(desc_access),
        .desc_flags(desc_flags), .cpl(cpl), .acc_kind(acc_kind), .long_mode(long_mode),
        .offset(offset), .acc_size(acc_size),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
        .rsp_lin_addr(rsp_lin_addr), .rsp_access(rsp_access)
    );

    task automatic check(input bit cond, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // reference model written from the requirements
    function automatic void ref_model(output int f, output logic [31:0] lin, output logic [7:0] wb);
        int  dpl  = int'(desc_access[6:5]);
        int  cp   = int'(cpl);
        bit  code = desc_access[3];
        bit  perm = desc_access[1];
        bit  dc   = desc_access[2];
        bit  tbad, pbad, lbad;
        longint eff, last, off;
        case (acc_kind)
            2'd0: tbad = code && !perm;
            2'd1: tbad = code || !perm;
            2'd2: tbad = !code;
            default: tbad = 1;
        endcase
        if (!code)   pbad = cp > dpl;
        else if (dc) pbad = cp < dpl;
        else         pbad = cp != dpl;
        off  = longint'(offset);
        eff  = desc_flags[2] ? longint'(desc_limit) * 4096 + 4095 : longint'(desc_limit);
        last = off + ((acc_size == 0) ? 0 : longint'(acc_size) - 1);
        if (!code && dc) lbad = (off <= eff) || (last > 64'hFFFF_FFFF);
        else             lbad = last > eff;
        if (!desc_access[7])                    f = 1;
        else if (!desc_access[4])               f = 2;
        else if (desc_flags[0] && desc_flags[1]) f = 3;
        else if (tbad)                          f = 4;
        else if (pbad)                          f = 5;
        else if (!long_mode && lbad)            f = 6;
        else                                    f = 0;
        lin = long_mode ? offset : desc_base + offset;
        wb  = (f == 0) ? (desc_access | 8'h01) : desc_access;
    endfunction

    // apply one request at a falling edge, compare at the next falling edge
    task automatic send(input string tag, input logic [31:0] b, input logic [19:0] lim,
                        input logic [7:0] ab, input logic [2:0] fl, input logic [1:0] cp,
                        input logic [1:0] k, input logic lm, input logic [31:0] off,
                        input logic [3:0] sz);
        int          ef;
        logic [31:0] el;
        logic [7:0]  ea;
        req_valid = 1; desc_base = b; desc_limit = lim; desc_access = ab; desc_flags = fl;
        cpl = cp; acc_kind = k; long_mode = lm; offset = off; acc_size = sz;
        ref_model(ef, el, ea);
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b1, {tag, " valid R1"}, rsp_valid, 1);
        check(int'(rsp_fault) == ef, {tag, " fault"}, rsp_fault, ef);
        check(rsp_ok == (ef == 0), {tag, " ok R2"}, rsp_ok, ef == 0);
        check(rsp_lin_addr == el, {tag, " addr R11"}, rsp_lin_addr, el);
        check(rsp_access == ea, {tag, " wb R12"}, rsp_access, ea);
    endtask

    task automatic idle();
        req_valid = 0;
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "idle R1", rsp_valid, 0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; desc_base = 0; desc_limit = 0; desc_access = 0;
        desc_flags = 0; cpl = 0; acc_kind = 0; long_mode = 0; offset = 0; acc_size = 0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check({rsp_valid, rsp_ok, rsp_fault, rsp_lin_addr, rsp_access} == '0,
              "reset R1", {rsp_valid, rsp_ok, rsp_fault}, 0);
        rst_n = 1;
        idle();
        // R2 absent beats everything else
        send("R2 absent",  32'h1000, 20'hFFFFF, 8'h12, 3'b011, 2'd3, 2'd2, 0, 32'h0, 4'd1);
        // R3 system segment
        send("R3 system",  32'h1000, 20'hFFFFF, 8'h82, 3'b000, 2'd0, 2'd0, 0, 32'h0, 4'd1);
        // R4 wide plus 32-bit flags
        send("R4 desc",    32'h0, 20'hFFFFF, 8'h9A, 3'b111, 2'd0, 2'd2, 1, 32'h0, 4'd1);
        // R5 type rules
        send("R5 execdata", 32'h0, 20'hFFFFF, 8'h92, 3'b100, 2'd0, 2'd2, 0, 32'h10, 4'd1);
        send("R5 wrcode",   32'h0, 20'hFFFFF, 8'h9A, 3'b100, 2'd0, 2'd1, 0, 32'h10, 4'd1);
        send("R5 rdxonly",  32'h0, 20'hFFFFF, 8'h98, 3'b100, 2'd0, 2'd0, 0, 32'h10, 4'd1);
        send("R5 wrro",     32'h0, 20'hFFFFF, 8'h90, 3'b100, 2'd0, 2'd1, 0, 32'h10, 4'd1);
        send("R5 rdro ok",  32'h0, 20'hFFFFF, 8'h90, 3'b100, 2'd0, 2'd0, 0, 32'h10, 4'd1);
        send("R5 rsvd",     32'h0, 20'hFFFFF, 8'h92, 3'b100, 2'd0, 2'd3, 0, 32'h10, 4'd1);
        // R6 privilege
        send("R6 data hi",  32'h0, 20'hFFFFF, 8'h92, 3'b100, 2'd3, 2'd0, 0, 32'h10, 4'd1);
        send("R6 data ok",  32'h0, 20'hFFFFF, 8'hF2, 3'b100, 2'd1, 2'd0, 0, 32'h10, 4'd1);
        send("R6 conf ok",  32'h0, 20'hFFFFF, 8'hDE, 3'b100, 2'd3, 2'd2, 0, 32'h10, 4'd1);
        send("R6 conf bad", 32'h0, 20'hFFFFF, 8'hDE, 3'b100, 2'd0, 2'd2, 0, 32'h10, 4'd1);
        send("R6 nc eq",    32'h0, 20'hFFFFF, 8'hDA, 3'b100, 2'd2, 2'd2, 0, 32'h10, 4'd1);
        send("R6 nc ne",    32'h0, 20'hFFFFF, 8'hDA, 3'b100, 2'd3, 2'd2, 0, 32'h10, 4'd1);
        // R7 granularity
        send("R7 page in",  32'h0, 20'h00001, 8'h92, 3'b100, 2'd0, 2'd0, 0, 32'h1FFF, 4'd1);
        send("R7 page out", 32'h0, 20'h00001, 8'h92, 3'b100, 2'd0, 2'd0, 0, 32'h2000, 4'd1);
        send("R7 byte out", 32'h0, 20'h00001, 8'h92, 3'b000, 2'd0, 2'd0, 0, 32'h2, 4'd1);
        // R8 last-byte limit and wrap
        send("R8 fit",      32'h0, 20'h000FF, 8'h92, 3'b000, 2'd0, 2'd1, 0, 32'hFC, 4'd4);
        send("R8 over",     32'h0, 20'h000FF, 8'h92, 3'b000, 2'd0, 2'd1, 0, 32'hFC, 4'd5);
        send("R8 size0",    32'h0, 20'h000FF, 8'h92, 3'b000, 2'd0, 2'd1, 0, 32'hFF, 4'd0);
        send("R8 wrap",     32'h0, 20'hFFFFF, 8'h92, 3'b100, 2'd0, 2'd0, 0, 32'hFFFF_FFFF, 4'd2);
        send("R8 top ok",   32'h0, 20'hFFFFF, 8'h92, 3'b100, 2'd0, 2'd0, 0, 32'hFFFF_FFFF, 4'd1);
        // R9 grow-down
        send("R9 at lim",   32'h0, 20'h000FF, 8'h96, 3'b000, 2'd0, 2'd0, 0, 32'hFF, 4'd1);
        send("R9 above",    32'h0, 20'h000FF, 8'h96, 3'b000, 2'd0, 2'd0, 0, 32'h100, 4'd1);
        send("R9 wrap",     32'h0, 20'h000FF, 8'h96, 3'b000, 2'd0, 2'd0, 0, 32'hFFFF_FFFE, 4'd4);
        // R10 wide mode skips base and limit
        send("R10 wide",    32'h5000, 20'h0, 8'h9A, 3'b001, 2'd0, 2'd2, 1, 32'h8000_0000, 4'd8);
        // R11 base addition wraps
        send("R11 wrap",    32'hFFFF_FF00, 20'hFFFFF, 8'h92, 3'b100, 2'd0, 2'd0, 0, 32'h200, 4'd1);
        // R12 touched bit already set stays set; fault keeps byte
        send("R12 keep",    32'h0, 20'h0, 8'h93, 3'b000, 2'd0, 2'd0, 0, 32'h4, 4'd1);
        idle();
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] lim = 20'($urandom);
            logic [31:0] off;
            logic [7:0]  ab  = 8'($urandom) | 8'h90;
            logic [2:0]  fl  = 3'($urandom) & 3'b110;
            if (i % 7 == 0) ab = 8'($urandom);
            if (i % 11 == 0) fl = 3'($urandom);
            off = fl[2] ? {lim, 12'hFFF} : {12'h0, lim};
            off = off + 32'($signed(4'($urandom)) );
            if (i % 5 == 0) off = $urandom;
            send("Rnd R2", $urandom, lim, ab, fl, 2'($urandom), 2'($urandom),
                 ($urandom % 8) == 0, off, 4'($urandom));
            if (i % 50 == 0) idle();
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule